// File: doc/BRIEF.md
# Interrupt-Capable GPIO Controller

A register-mapped general-purpose I/O controller for up to 32 pins. Each pin is a plain input, a plain output, or an interrupt source. Software drives the configuration over a simple word-addressed register bus. A write is taken on the rising clock edge when the write strobe is high. A read is combinational from the address.

Pins in interrupt mode are sensed either by level or by edge. Each pin has its own polarity-invert bit, which applies to both kinds of sensing. Every interrupt pin has a pending-status bit. The status bits are gated by a per-pin enable and ORed into one interrupt line.

Enables are changed through two write-only paths. The mask register clears the enable of every pin written as 0. The unmask port sets the enable of every pin written as 1.

Top module: `pio_irq_ctrl`

## Requirements
- R1: After reset, every readable register reads 0, `pin_oe_o` and `pin_o` are 0 and `irq_o` is 0; all pins are masked.
- R2: Registers read back as written: mode at 0x00, direction at 0x04, output data at 0x08, polarity at 0x20, edge select at 0x24, filter enable at 0x28. The clear port at 0x14, the unmask port at 0x1C, any other address and any unaligned address read 0. The filter-enable bits have no effect on pins or status.
- R3: `pin_o` equals the output-data register and `pin_oe_o` equals the direction register (1 = output) from the clock edge that takes the write.
- R4: Address 0x0C reads each pin's level after two synchronising flip-flops, so a change is visible after the second rising edge.
- R5: A pin whose mode bit (0x00) is 0 never holds a status bit and never contributes to `irq_o`.
- R6: In edge mode (edge-select bit 1), polarity bit 0 flags a rising edge and polarity bit 1 flags a falling edge. The status bit (0x10) is sticky and set on the third rising edge after the pin change.
- R7: In level mode (edge-select bit 0), the status bit equals the synchronised pin XOR its polarity bit, with the same latency as R6. Clear writes do not affect it.
- R8: Writing 1 to a bit at 0x14 clears that edge-mode status bit on the taking edge; bits written 0 are unchanged.
- R9: When a new edge and a clear of the same pin meet on one clock edge, the status bit stays set.
- R10: A write to 0x18 disables every pin whose written bit is 0 and keeps the enable of pins written 1; 0x18 reads the enables (1 = unmasked).
- R11: Writing 1 to a bit at 0x1C enables that pin; bits written 0 are unchanged.
- R12: `irq_o` is high exactly when some status bit and its enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 6 | Byte address of the register |
| bus_we_i | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| pin_i | input | 32 | Pin levels, asynchronous |
| pin_o | output | 32 | Output levels |
| pin_oe_o | output | 32 | Output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
Register writes land on the edge that samples the strobe, and reads follow the address in the same cycle. The input-data view trails a pin change by two rising edges. Status and `irq_o` trail it by three. The bench advances a behavioural model of these delays on each rising edge and compares every output and the addressed read value on the following falling edge, so each result is sampled in the cycle it is due. The same-edge edge/clear case is placed by counting those three edges from the pin change.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int unsigned PIO_AW = 6;

    localparam logic [PIO_AW-1:0] OFS_MODE   = 6'h00;
    localparam logic [PIO_AW-1:0] OFS_DIR    = 6'h04;
    localparam logic [PIO_AW-1:0] OFS_DOUT   = 6'h08;
    localparam logic [PIO_AW-1:0] OFS_DIN    = 6'h0C;
    localparam logic [PIO_AW-1:0] OFS_STAT   = 6'h10;
    localparam logic [PIO_AW-1:0] OFS_CLR    = 6'h14;
    localparam logic [PIO_AW-1:0] OFS_MASK   = 6'h18;
    localparam logic [PIO_AW-1:0] OFS_UNMASK = 6'h1C;
    localparam logic [PIO_AW-1:0] OFS_INV    = 6'h20;
    localparam logic [PIO_AW-1:0] OFS_EDGE   = 6'h24;
    localparam logic [PIO_AW-1:0] OFS_FILT   = 6'h28;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pio_sense.sv
module pio_sense #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] mode_i,
    input  logic [W-1:0] edge_i,
    input  logic [W-1:0] inv_i,
    output logic [W-1:0] edge_evt_o,
    output logic [W-1:0] active_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic now_hi, was_hi;
        assign now_hi        = lvl_i[i] ^ inv_i[i];
        assign was_hi        = prev_q[i] ^ inv_i[i];
        assign edge_evt_o[i] = mode_i[i] & edge_i[i] & now_hi & ~was_hi;
        assign active_o[i]   = mode_i[i] & ~edge_i[i] & now_hi;
    end
endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux
    import pio_pkg::*;
#(
    parameter int unsigned NPINS = 32,
    parameter int unsigned DW    = 32
) (
    input  logic [PIO_AW-1:0] addr_i,
    input  logic [NPINS-1:0]  mode_i,
    input  logic [NPINS-1:0]  dir_i,
    input  logic [NPINS-1:0]  dout_i,
    input  logic [NPINS-1:0]  din_i,
    input  logic [NPINS-1:0]  stat_i,
    input  logic [NPINS-1:0]  en_i,
    input  logic [NPINS-1:0]  inv_i,
    input  logic [NPINS-1:0]  edge_i,
    input  logic [NPINS-1:0]  filt_i,
    output logic [DW-1:0]     rdata_o
);
    logic [NPINS-1:0] sel;

    always_comb begin
        case (addr_i)
            OFS_MODE: sel = mode_i;
            OFS_DIR:  sel = dir_i;
            OFS_DOUT: sel = dout_i;
            OFS_DIN:  sel = din_i;
            OFS_STAT: sel = stat_i;
            OFS_MASK: sel = en_i;
            OFS_INV:  sel = inv_i;
            OFS_EDGE: sel = edge_i;
            OFS_FILT: sel = filt_i;
            default:  sel = '0;
        endcase
        rdata_o = DW'(sel);
    end
endmodule

// File: rtl/pio_irq_ctrl.sv
module pio_irq_ctrl
    import pio_pkg::*;
#(
    parameter int unsigned NPINS = 32,
    parameter int unsigned DW    = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [PIO_AW-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DW-1:0]     bus_wdata_i,
    output logic [DW-1:0]     bus_rdata_o,
    input  logic [NPINS-1:0]  pin_i,
    output logic [NPINS-1:0]  pin_o,
    output logic [NPINS-1:0]  pin_oe_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [NPINS-1:0] mode;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] pend;
        logic [NPINS-1:0] en;
        logic [NPINS-1:0] inv;
        logic [NPINS-1:0] edg;
        logic [NPINS-1:0] filt;
    } state_t;

    state_t           s_d, s_q;
    logic [NPINS-1:0] wbits;
    logic [NPINS-1:0] clr;
    logic [NPINS-1:0] lvl;
    logic [NPINS-1:0] evt;
    logic [NPINS-1:0] act;

    assign wbits = bus_wdata_i[NPINS-1:0];

    pio_sync #(.W(NPINS), .STAGES(2)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pin_i),
        .q_o    (lvl)
    );

    pio_sense #(.W(NPINS)) u_sense (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .lvl_i      (lvl),
        .mode_i     (s_q.mode),
        .edge_i     (s_q.edg),
        .inv_i      (s_q.inv),
        .edge_evt_o (evt),
        .active_o   (act)
    );

    always_comb begin
        s_d = s_q;
        clr = '0;
        if (bus_we_i) begin
            case (bus_addr_i)
                OFS_MODE:   s_d.mode = wbits;
                OFS_DIR:    s_d.dir  = wbits;
                OFS_DOUT:   s_d.dout = wbits;
                OFS_CLR:    clr      = wbits;
                OFS_MASK:   s_d.en   = s_q.en & wbits;
                OFS_UNMASK: s_d.en   = s_q.en | wbits;
                OFS_INV:    s_d.inv  = wbits;
                OFS_EDGE:   s_d.edg  = wbits;
                OFS_FILT:   s_d.filt = wbits;
                default:    ;
            endcase
        end
        // edge pins keep sticky status, a new edge beats a clear; level pins track
        s_d.pend = (s_q.mode & s_q.edg & ((s_q.pend & ~clr) | evt)) | act;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    pio_rdmux #(.NPINS(NPINS), .DW(DW)) u_rdmux (
        .addr_i  (bus_addr_i),
        .mode_i  (s_q.mode),
        .dir_i   (s_q.dir),
        .dout_i  (s_q.dout),
        .din_i   (lvl),
        .stat_i  (s_q.pend),
        .en_i    (s_q.en),
        .inv_i   (s_q.inv),
        .edge_i  (s_q.edg),
        .filt_i  (s_q.filt),
        .rdata_o (bus_rdata_o)
    );

    assign pin_o    = s_q.dout;
    assign pin_oe_o = s_q.dir;
    assign irq_o    = |(s_q.pend & s_q.en);
endmodule

// File: rtl/pio_irq_ctrl_chk.sv
module pio_irq_ctrl_chk
    import pio_pkg::*;
#(
    parameter int unsigned NPINS = 32,
    parameter int unsigned DW    = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [PIO_AW-1:0] bus_addr_i,
    input logic              bus_we_i,
    input logic [DW-1:0]     bus_wdata_i,
    input logic [NPINS-1:0]  pin_oe_o,
    input logic              irq_o,
    input logic [NPINS-1:0]  stat_i,
    input logic [NPINS-1:0]  en_i,
    input logic [NPINS-1:0]  mode_i
);
    // R3: direction write reaches the output enables on the taking edge
    a_r3_dir_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == OFS_DIR) |=> (pin_oe_o == $past(bus_wdata_i[NPINS-1:0])));

    // R5: no status on a pin that was in general I/O mode
    a_r5_gpio_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((stat_i & ~$past(mode_i)) == '0));

    // R10: bits written 0 to the mask register end up disabled
    a_r10_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == OFS_MASK) |=> ((en_i & ~$past(bus_wdata_i[NPINS-1:0])) == '0));

    // R11: bits written 1 to the unmask port end up enabled
    a_r11_unmask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == OFS_UNMASK) |=> ((~en_i & $past(bus_wdata_i[NPINS-1:0])) == '0));

    // R12: with every pin masked the line stays low
    a_r12_masked_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i == '0) |-> !irq_o);
endmodule

bind pio_irq_ctrl pio_irq_ctrl_chk #(.NPINS(NPINS), .DW(DW)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .pin_oe_o    (pin_oe_o),
    .irq_o       (irq_o),
    .stat_i      (s_q.pend),
    .en_i        (s_q.en),
    .mode_i      (s_q.mode)
);

// File: tb/pio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module pio_irq_ctrl_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [5:0]  bus_addr_i = '0;
    logic        bus_we_i = 1'b0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic [31:0] pin_i = '0;
    logic [31:0] pin_o;
    logic [31:0] pin_oe_o;
    logic        irq_o;

    int n_run = 0;
    int n_fail = 0;
    bit go = 1'b0;
    bit done = 1'b0;

    always #10 clk_i = ~clk_i;

    pio_irq_ctrl dut_i (
        .clk_i, .rst_ni, .bus_addr_i, .bus_we_i, .bus_wdata_i,
        .bus_rdata_o, .pin_i, .pin_o, .pin_oe_o, .irq_o
    );

    // behavioural reference
    bit [31:0] m_mode, m_dir, m_out, m_pend, m_en, m_pol, m_edg, m_filt;
    bit [31:0] seen1, seen2, seen3; // pin samples 1, 2 and 3 edges old

    always @(posedge clk_i) begin
        if (!rst_ni) begin
            m_mode = 0; m_dir = 0; m_out = 0; m_pend = 0; m_en = 0;
            m_pol = 0; m_edg = 0; m_filt = 0; seen1 = 0; seen2 = 0; seen3 = 0;
        end else begin
            bit [31:0] clrw, np;
            clrw = (bus_we_i && bus_addr_i == 6'h14) ? bus_wdata_i : 32'h0;
            for (int i = 0; i < 32; i++) begin
                bit cur, old;
                cur = seen2[i] ^ m_pol[i];
                old = seen3[i] ^ m_pol[i];
                if (!m_mode[i])    np[i] = 1'b0;
                else if (m_edg[i]) np[i] = (m_pend[i] && !clrw[i]) || (cur && !old);
                else               np[i] = cur;
            end
            m_pend = np;
            if (bus_we_i) begin
                case (bus_addr_i)
                    6'h00: m_mode = bus_wdata_i;
                    6'h04: m_dir  = bus_wdata_i;
                    6'h08: m_out  = bus_wdata_i;
                    6'h18: m_en   = m_en & bus_wdata_i;
                    6'h1C: m_en   = m_en | bus_wdata_i;
                    6'h20: m_pol  = bus_wdata_i;
                    6'h24: m_edg  = bus_wdata_i;
                    6'h28: m_filt = bus_wdata_i;
                    default: ;
                endcase
            end
            seen3 = seen2; seen2 = seen1; seen1 = pin_i;
        end
    end

    function automatic bit [31:0] model_read(bit [5:0] a);
        case (a)
            6'h00: return m_mode;
            6'h04: return m_dir;
            6'h08: return m_out;
            6'h0C: return seen2;
            6'h10: return m_pend;
            6'h18: return m_en;
            6'h20: return m_pol;
            6'h24: return m_edg;
            6'h28: return m_filt;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(bit [5:0] a);
        case (a)
            6'h0C: return "R4 input data";
            6'h10: return "R5 R6 R7 R8 R9 status";
            6'h18: return "R10 R11 enables";
            default: return "R2 readback";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison on the falling edge
    always @(negedge clk_i) begin
        if (go && rst_ni) begin
            check("R3 pin_o", pin_o, m_out);
            check("R3 pin_oe_o", pin_oe_o, m_dir);
            check("R12 irq_o", {31'b0, irq_o}, {31'b0, |(m_pend & m_en)});
            check(read_tag(bus_addr_i), bus_rdata_o, model_read(bus_addr_i));
        end
    end

    task automatic bus(bit we, bit [5:0] a, bit [31:0] d);
        @(negedge clk_i);
        #1;
        bus_we_i = we; bus_addr_i = a; bus_wdata_i = d;
    endtask

    bit [31:0] lfsr = 32'hACE1_2B3D;
    function automatic bit [31:0] nxt(bit [31:0] v);
        return v[0] ? ((v >> 1) ^ 32'hA300_0001) : (v >> 1);
    endfunction

    initial begin
        repeat (4) @(negedge clk_i);
        rst_ni = 1'b1;
        go = 1'b1;
        // R1: reset state through every address
        for (int a = 0; a < 12; a++) begin
            bus(1'b0, 6'(a * 4), 32'h0);
            @(negedge clk_i);
            check("R1 reset read", bus_rdata_o, 32'h0);
            check("R1 reset irq", {31'b0, irq_o}, 32'h0);
            check("R1 reset oe", pin_oe_o, 32'h0);
        end
        // R2: readback, unaligned address reads 0
        bus(1'b1, 6'h28, 32'h5A5A_0FF0);
        bus(1'b1, 6'h04, 32'h0000_FFFF);
        bus(1'b1, 6'h08, 32'h1234_5678);
        bus(1'b0, 6'h01, 32'h0);
        @(negedge clk_i);
        check("R2 unaligned", bus_rdata_o, 32'h0);
        // R9 then R8: pin 16 rising edge, interrupt mode, unmasked
        bus(1'b1, 6'h00, 32'h0001_0000);
        bus(1'b1, 6'h24, 32'h0001_0000);
        bus(1'b1, 6'h1C, 32'h0001_0000);
        bus(1'b0, 6'h10, 32'h0);
        repeat (4) @(negedge clk_i);
        #1 pin_i[16] = 1'b1;               // sampled on the next rising edge
        @(negedge clk_i);
        bus(1'b1, 6'h14, 32'h0001_0000);   // clear meets the status-setting edge
        bus(1'b0, 6'h10, 32'h0);
        @(negedge clk_i);
        check("R9 edge beats clear", bus_rdata_o & 32'h0001_0000, 32'h0001_0000);
        check("R9 irq", {31'b0, irq_o}, 32'h1);
        bus(1'b1, 6'h14, 32'hFFFE_FFFF);   // zeros on pin 16 leave it
        bus(1'b0, 6'h10, 32'h0);
        @(negedge clk_i);
        check("R8 zero bits keep", bus_rdata_o & 32'h0001_0000, 32'h0001_0000);
        bus(1'b1, 6'h14, 32'h0001_0000);
        bus(1'b0, 6'h10, 32'h0);
        @(negedge clk_i);
        check("R8 clear", bus_rdata_o, 32'h0);
        check("R12 irq low after clear", {31'b0, irq_o}, 32'h0);
        // mixed traffic: R4 R5 R6 R7 R10 R11 R12 against the model
        bus(1'b1, 6'h00, 32'hFFFF_0F00);
        bus(1'b1, 6'h24, 32'h00FF_00FF);
        bus(1'b1, 6'h20, 32'h0F0F_3C3C);
        bus(1'b1, 6'h1C, 32'hFFFF_FFFF);
        for (int c = 0; c < 4000; c++) begin
            bit [31:0] r, d;
            lfsr = nxt(lfsr); r = lfsr;
            lfsr = nxt(lfsr); d = lfsr;
            @(negedge clk_i);
            #1;
            if (r[2:0] == 3'd0) pin_i = pin_i ^ (d & r);
            else if (r[2:0] == 3'd1) pin_i = pin_i ^ (32'h1 << r[12:8]);
            bus_addr_i  = 6'((r[19:16] % 12) * 4);
            bus_wdata_i = d;
            bus_we_i    = (r[23:20] < 4'd3) && (r[19:16] % 12 != 0 || r[24]);
        end
        bus(1'b0, 6'h10, 32'h0);
        repeat (4) @(negedge clk_i);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule